// File: doc/BRIEF.md
# Two-Dimensional XOR Parity Packet Recovery Unit

This unit holds one protection matrix of media packets, L columns by D rows, together with the column parity packets and row parity packets that protect it. An upstream receiver writes packets into the unit one word at a time. Media and parity packets come on separate write ports and are placed by index, so arrival order does not matter. A media packet or parity packet counts as received only when its last word is written.

When the receiver decides the matrix is finished, it pulses `close`. This happens either when every packet is in or when its own timeout expires. The unit then sweeps all columns, then all rows, then columns again, and so on. A column or row with exactly one missing media packet, whose parity packet is present, gets that packet rebuilt: the missing packet is the XOR of the parity packet and every other media packet in that line. Column sweeps repair burst losses. Row sweeps repair scattered losses that hit a column twice. A packet rebuilt in one sweep can open up a line in the other direction.

Each rebuilt packet is streamed out word by word, tagged with its slot number. A one-cycle completion pulse then reports how many slots remain missing. Packets that cannot be rebuilt are never emitted. After the completion pulse the matrix is empty again and ready for the next one.

Top module: `fec_xor_recover`

## Requirements
- R1: A line (column or row) is repaired only when exactly one of its media packets is missing and its parity packet is received. Every emitted word equals the XOR of the parity word and the same-numbered words of the other media packets of that line.
- R2: Slot numbers run row by row: slot = row*L + column, so column c holds slots c, c+L, c+2L, and so on. Parity is matched to its line by the index written with it, whatever the write order. A burst of L consecutive lost slots is fully repaired with column parity alone.
- R3: The first sweep after `close` covers columns, and sweeps then alternate between columns and rows. Recovery ends when a sweep other than the first repairs nothing, or after 2L+2 sweeps.
- R4: For each rebuilt packet, `out_valid` is high for WORDS consecutive cycles with `out_word` counting 0 to WORDS-1. `out_first` is high only on word 0, and `out_slot` is constant across the packet.
- R5: Slots that cannot be repaired are never emitted. `done` is high for exactly one cycle at the end of recovery, and `unrec_cnt` then equals the number of slots still missing.
- R6: If some parity packets never arrived, recovery runs with the parity packets that did arrive. A line whose own parity is absent may still be repaired through the other direction.
- R7: While `busy` is high, writes on the media and parity ports have no effect.
- R8: A packet counts as received only when word WORDS-1 is written. After `done`, every media and parity slot is empty again.
- R9: After reset, `busy`, `out_valid` and `done` are low and `unrec_cnt` equals L*D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| media_we | input | 1 | Media word write strobe |
| media_slot | input | clog2(L*D) | Media slot number, row*L+column |
| media_word | input | clog2(WORDS) | Word number within the packet |
| media_data | input | W | Media word |
| par_we | input | 1 | Parity word write strobe |
| par_row | input | 1 | 0: column parity, 1: row parity |
| par_idx | input | clog2(max(L,D)) | Column or row index of the parity packet |
| par_word | input | clog2(WORDS) | Word number within the parity packet |
| par_data | input | W | Parity word |
| close | input | 1 | Start recovery on the current matrix |
| busy | output | 1 | Recovery in progress |
| out_valid | output | 1 | Rebuilt word valid |
| out_first | output | 1 | First word of a rebuilt packet |
| out_slot | output | clog2(L*D) | Slot of the rebuilt packet |
| out_word | output | clog2(WORDS) | Word number of the rebuilt word |
| out_data | output | W | Rebuilt word |
| done | output | 1 | One-cycle end-of-recovery pulse |
| unrec_cnt | output | clog2(L*D+1) | Slots still missing |

## Verification
A stale received bit shows up in two ways: at the next `done` as a wrong `unrec_cnt`, or as a slot that goes missing from or appears in the emitted set. Either one is visible within the same matrix run. A wrong XOR term or a mismatched parity index corrupts `out_data` on the very word where it is used, so every emitted word is compared with the packet originally sent. Sweep ordering errors change the order of `out_slot` values in a loss pattern that needs column, row and column sweeps. A sweep that stops too early leaves slots unrepaired, and `unrec_cnt` shows it at the `done` pulse.

// File: rtl/fec_pkg.sv
package fec_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_EVAL  = 2'd1,
    S_BUILD = 2'd2,
    S_FINISH = 2'd3
  } fec_state_e;
endpackage

// File: rtl/fec_store.sv
// Matrix storage: media words, parity words and their received flags.
module fec_store #(
  parameter int L = 4,
  parameter int D = 4,
  parameter int W = 8,
  parameter int WORDS = 4,
  localparam int SLOTS = L * D,
  localparam int SW = $clog2(SLOTS),
  localparam int WW = $clog2(WORDS),
  localparam int IW = $clog2((L > D) ? L : D),
  localparam int MA = $clog2(SLOTS * WORDS),
  localparam int CA = $clog2(L * WORDS),
  localparam int RA = $clog2(D * WORDS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ext_en,
  input  logic                              media_we,
  input  logic [SW-1:0]                     media_slot,
  input  logic [WW-1:0]                     media_word,
  input  logic [W-1:0]                      media_data,
  input  logic                              par_we,
  input  logic                              par_row,
  input  logic [IW-1:0]                     par_idx,
  input  logic [WW-1:0]                     par_word,
  input  logic [W-1:0]                      par_data,
  input  logic                              rec_we,
  input  logic [SW-1:0]                     rec_slot,
  input  logic [WW-1:0]                     rec_word,
  input  logic [W-1:0]                      rec_data,
  input  logic                              clear,
  output logic [SLOTS*WORDS-1:0][W-1:0]     media,
  output logic [SLOTS-1:0]                  rcvd,
  output logic [L*WORDS-1:0][W-1:0]         colp,
  output logic [D*WORDS-1:0][W-1:0]         rowp,
  output logic [L-1:0]                      col_ok,
  output logic [D-1:0]                      row_ok
);
  logic          m_ext, c_ext, r_ext, m_wr;
  logic [MA-1:0] m_addr;
  logic [W-1:0]  m_data;
  logic [CA-1:0] c_addr;
  logic [RA-1:0] r_addr;
  logic          last_m, last_p, last_r;

  logic [SLOTS-1:0] rcvd_d, rcvd_q;
  logic [L-1:0]     col_ok_d, col_ok_q;
  logic [D-1:0]     row_ok_d, row_ok_q;

  assign m_ext  = ext_en && media_we && ({1'b0, media_slot} < (SW+1)'(SLOTS));
  assign c_ext  = ext_en && par_we && !par_row && ({1'b0, par_idx} < (IW+1)'(L));
  assign r_ext  = ext_en && par_we &&  par_row && ({1'b0, par_idx} < (IW+1)'(D));
  assign last_m = (media_word == WW'(WORDS - 1));
  assign last_p = (par_word == WW'(WORDS - 1));
  assign last_r = (rec_word == WW'(WORDS - 1));

  always_comb begin
    m_wr = rec_we || m_ext;
    if (rec_we) begin
      m_addr = MA'(rec_slot) * MA'(WORDS) + MA'(rec_word);
      m_data = rec_data;
    end else begin
      m_addr = MA'(media_slot) * MA'(WORDS) + MA'(media_word);
      m_data = media_data;
    end
    c_addr = CA'(par_idx) * CA'(WORDS) + CA'(par_word);
    r_addr = RA'(par_idx) * RA'(WORDS) + RA'(par_word);
  end

  // Data words: write-enabled, no reset needed.
  always_ff @(posedge clk) begin
    if (m_wr)  media[m_addr] <= m_data;
    if (c_ext) colp[c_addr]  <= par_data;
    if (r_ext) rowp[r_addr]  <= par_data;
  end

  always_comb begin
    rcvd_d   = rcvd_q;
    col_ok_d = col_ok_q;
    row_ok_d = row_ok_q;
    if (clear) begin
      rcvd_d   = '0;
      col_ok_d = '0;
      row_ok_d = '0;
    end else begin
      if (m_ext && last_m)   rcvd_d[media_slot] = 1'b1;
      if (rec_we && last_r)  rcvd_d[rec_slot] = 1'b1;
      if (c_ext && last_p)   col_ok_d[$clog2(L)'(par_idx)] = 1'b1;
      if (r_ext && last_p)   row_ok_d[$clog2(D)'(par_idx)] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcvd_q   <= '0;
      col_ok_q <= '0;
      row_ok_q <= '0;
    end else begin
      rcvd_q   <= rcvd_d;
      col_ok_q <= col_ok_d;
      row_ok_q <= row_ok_d;
    end
  end

  assign rcvd   = rcvd_q;
  assign col_ok = col_ok_q;
  assign row_ok = row_ok_q;

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && !clear) |=> ($stable(col_ok_q) && $stable(row_ok_q))); // R7
endmodule

// File: rtl/fec_line_eval.sv
// Examines one column or row: missing count, missing slot, parity presence,
// and the XOR rebuild of one word position.
module fec_line_eval #(
  parameter int L = 4,
  parameter int D = 4,
  parameter int W = 8,
  parameter int WORDS = 4,
  localparam int SLOTS = L * D,
  localparam int SW = $clog2(SLOTS),
  localparam int WW = $clog2(WORDS),
  localparam int IW = $clog2((L > D) ? L : D),
  localparam int MA = $clog2(SLOTS * WORDS),
  localparam int CA = $clog2(L * WORDS),
  localparam int RA = $clog2(D * WORDS)
) (
  input  logic                          dim_row,
  input  logic [IW-1:0]                 idx,
  input  logic [WW-1:0]                 word,
  input  logic [SLOTS*WORDS-1:0][W-1:0] media,
  input  logic [SLOTS-1:0]              rcvd,
  input  logic [L*WORDS-1:0][W-1:0]     colp,
  input  logic [D*WORDS-1:0][W-1:0]     rowp,
  input  logic [L-1:0]                  col_ok,
  input  logic [D-1:0]                  row_ok,
  output logic                          miss_one,
  output logic [SW-1:0]                 miss_slot,
  output logic                          par_ok,
  output logic [W-1:0]                  rebuilt
);
  logic [1:0] cnt;

  always_comb begin
    cnt       = '0;
    miss_slot = '0;
    rebuilt   = '0;
    par_ok    = 1'b0;
    if (!dim_row) begin
      for (int r = 0; r < D; r++) begin
        if (!rcvd[SW'(r * L + int'(idx))]) begin
          if (cnt != 2'd2) cnt = cnt + 2'd1;
          miss_slot = SW'(r * L + int'(idx));
        end else begin
          rebuilt = rebuilt ^ media[MA'((r * L + int'(idx)) * WORDS + int'(word))];
        end
      end
      rebuilt = rebuilt ^ colp[CA'(int'(idx) * WORDS + int'(word))];
      par_ok  = col_ok[$clog2(L)'(idx)];
    end else begin
      for (int c = 0; c < L; c++) begin
        if (!rcvd[SW'(int'(idx) * L + c)]) begin
          if (cnt != 2'd2) cnt = cnt + 2'd1;
          miss_slot = SW'(int'(idx) * L + c);
        end else begin
          rebuilt = rebuilt ^ media[MA'((int'(idx) * L + c) * WORDS + int'(word))];
        end
      end
      rebuilt = rebuilt ^ rowp[RA'(int'(idx) * WORDS + int'(word))];
      par_ok  = row_ok[$clog2(D)'(idx)];
    end
  end

  assign miss_one = (cnt == 2'd1);
endmodule

// File: rtl/fec_xor_recover.sv
// Top: sweep controller alternating column and row passes.
module fec_xor_recover
  import fec_pkg::*;
#(
  parameter int L = 4,
  parameter int D = 4,
  parameter int W = 8,
  parameter int WORDS = 4,
  localparam int SLOTS = L * D,
  localparam int SW = $clog2(SLOTS),
  localparam int WW = $clog2(WORDS),
  localparam int IW = $clog2((L > D) ? L : D),
  localparam int CW = $clog2(SLOTS + 1),
  localparam int MAX_PASS = 2 * L + 2,
  localparam int PW = $clog2(MAX_PASS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          media_we,
  input  logic [SW-1:0] media_slot,
  input  logic [WW-1:0] media_word,
  input  logic [W-1:0]  media_data,
  input  logic          par_we,
  input  logic          par_row,
  input  logic [IW-1:0] par_idx,
  input  logic [WW-1:0] par_word,
  input  logic [W-1:0]  par_data,
  input  logic          close,
  output logic          busy,
  output logic          out_valid,
  output logic          out_first,
  output logic [SW-1:0] out_slot,
  output logic [WW-1:0] out_word,
  output logic [W-1:0]  out_data,
  output logic          done,
  output logic [CW-1:0] unrec_cnt
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  fec_state_e    state_q, state_d;
  logic          dim_q, dim_d, prog_q, prog_d;
  logic [IW-1:0] idx_q, idx_d, last_idx;
  logic [WW-1:0] word_q, word_d;
  logic [PW-1:0] pass_q, pass_d;
  logic [SW-1:0] slot_q, slot_d;

  logic [SLOTS*WORDS-1:0][W-1:0] media;
  logic [SLOTS-1:0]              rcvd;
  logic [L*WORDS-1:0][W-1:0]     colp;
  logic [D*WORDS-1:0][W-1:0]     rowp;
  logic [L-1:0]                  col_ok;
  logic [D-1:0]                  row_ok;
  logic                          miss_one, par_ok;
  logic [SW-1:0]                 miss_slot;
  logic [W-1:0]                  rebuilt;
  logic                          building;

  assign building = (state_q == S_BUILD);

  fec_store #(.L(L), .D(D), .W(W), .WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_ni), .ext_en(state_q == S_IDLE),
    .media_we(media_we), .media_slot(media_slot), .media_word(media_word),
    .media_data(media_data), .par_we(par_we), .par_row(par_row),
    .par_idx(par_idx), .par_word(par_word), .par_data(par_data),
    .rec_we(building), .rec_slot(slot_q), .rec_word(word_q), .rec_data(rebuilt),
    .clear(state_q == S_FINISH), .media(media), .rcvd(rcvd), .colp(colp),
    .rowp(rowp), .col_ok(col_ok), .row_ok(row_ok)
  );

  fec_line_eval #(.L(L), .D(D), .W(W), .WORDS(WORDS)) u_eval (
    .dim_row(dim_q), .idx(idx_q), .word(word_q), .media(media), .rcvd(rcvd),
    .colp(colp), .rowp(rowp), .col_ok(col_ok), .row_ok(row_ok),
    .miss_one(miss_one), .miss_slot(miss_slot), .par_ok(par_ok), .rebuilt(rebuilt)
  );

  assign last_idx = dim_q ? IW'(D - 1) : IW'(L - 1);

  always_comb begin
    state_d = state_q;
    dim_d   = dim_q;
    idx_d   = idx_q;
    word_d  = word_q;
    pass_d  = pass_q;
    prog_d  = prog_q;
    slot_d  = slot_q;
    unique case (state_q)
      S_IDLE: if (close) begin
        state_d = S_EVAL;
        dim_d   = 1'b0;
        idx_d   = '0;
        pass_d  = '0;
        prog_d  = 1'b0;
      end
      S_EVAL: begin
        if (miss_one && par_ok) begin
          state_d = S_BUILD;
          word_d  = '0;
          slot_d  = miss_slot;
        end else if (idx_q != last_idx) begin
          idx_d = idx_q + 1'b1;
        end else begin
          pass_d = pass_q + 1'b1;
          if ((!prog_q && pass_q != '0) || (pass_d == PW'(MAX_PASS))) begin
            state_d = S_FINISH;
          end else begin
            dim_d  = ~dim_q;
            idx_d  = '0;
            prog_d = 1'b0;
          end
        end
      end
      S_BUILD: begin
        word_d = word_q + 1'b1;
        if (word_q == WW'(WORDS - 1)) begin
          state_d = S_EVAL;
          prog_d  = 1'b1;
        end
      end
      S_FINISH: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      dim_q   <= 1'b0;
      idx_q   <= '0;
      word_q  <= '0;
      pass_q  <= '0;
      prog_q  <= 1'b0;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      dim_q   <= dim_d;
      idx_q   <= idx_d;
      word_q  <= word_d;
      pass_q  <= pass_d;
      prog_q  <= prog_d;
      slot_q  <= slot_d;
    end
  end

  always_comb begin
    unrec_cnt = CW'(SLOTS);
    for (int s = 0; s < SLOTS; s++) begin
      if (rcvd[s]) unrec_cnt = unrec_cnt - CW'(1);
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign out_valid = building;
  assign out_first = building && (word_q == '0);
  assign out_slot  = slot_q;
  assign out_word  = word_q;
  assign out_data  = rebuilt;
  assign done      = (state_q == S_FINISH);

  AST_BUILD_ONE_MISSING: assert property (@(posedge clk) disable iff (!rst_ni)
    building |-> (miss_one && par_ok && miss_slot == slot_q)); // R1
  AST_WORD_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && out_word != '0) |-> (out_slot == $past(out_slot) && out_word == $past(out_word) + 1'b1)); // R4
  AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    pass_q <= PW'(MAX_PASS)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> (!done && !busy)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (!out_valid && !done)); // R9
endmodule

// File: tb/fec_xor_recover_tb.sv
module fec_xor_recover_tb;
  localparam int L = 4, D = 4, W = 8, WORDS = 4, SLOTS = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, media_we, par_we, par_row, close;
  logic [3:0] media_slot;
  logic [1:0] media_word, par_word, out_word;
  logic [1:0] par_idx;
  logic [7:0] media_data, par_data, out_data;
  logic busy, out_valid, out_first, done;
  logic [3:0] out_slot;
  logic [4:0] unrec_cnt;

  fec_xor_recover #(.L(L), .D(D), .W(W), .WORDS(WORDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .media_we(media_we), .media_slot(media_slot),
    .media_word(media_word), .media_data(media_data), .par_we(par_we),
    .par_row(par_row), .par_idx(par_idx), .par_word(par_word), .par_data(par_data),
    .close(close), .busy(busy), .out_valid(out_valid), .out_first(out_first),
    .out_slot(out_slot), .out_word(out_word), .out_data(out_data), .done(done),
    .unrec_cnt(unrec_cnt)
  );

  int checks = 0, fails = 0;
  int rec_seq [SLOTS];
  int nrec;

  typedef struct packed {
    logic [7:0]  seed;
    logic [15:0] loss;
    logic [3:0]  cm;
    logic [3:0]  rm;
    logic [15:0] exp_rec;
    logic [7:0]  exp_un;
  } vec_t;

  // slot = row*4 + column
  localparam vec_t VECS [10] = '{
    '{8'd1,  16'h0000, 4'hF, 4'hF, 16'h0000, 8'd0},   // no loss
    '{8'd2,  16'h01E0, 4'hF, 4'h0, 16'h01E0, 8'd0},   // R2 burst of L
    '{8'd3,  16'h0011, 4'hF, 4'h0, 16'h0000, 8'd2},   // R5 double hit in column 0
    '{8'd4,  16'h0011, 4'hF, 4'hF, 16'h0011, 8'd0},   // rows fix it
    '{8'd5,  16'h0013, 4'hF, 4'h1, 16'h0013, 8'd0},   // R3 col,row,col
    '{8'd6,  16'h0033, 4'hF, 4'hF, 16'h0000, 8'd4},   // R5 square
    '{8'd7,  16'h0004, 4'hB, 4'h0, 16'h0000, 8'd1},   // R6 own parity absent
    '{8'd8,  16'h0004, 4'hB, 4'h1, 16'h0004, 8'd0},   // R6 row rescues
    '{8'd9,  16'hF000, 4'hF, 4'h0, 16'hF000, 8'd0},   // full row lost
    '{8'd10, 16'hFFFF, 4'hF, 4'hF, 16'h0000, 8'd16}   // everything lost
  };

  function automatic logic [7:0] pkt(logic [7:0] seed, int s, int w);
    return 8'(int'(seed) * 29 + s * 11 + w * 3 + 1);
  endfunction

  function automatic logic [7:0] cpar(logic [7:0] seed, int c, int w);
    logic [7:0] x = '0;
    for (int r = 0; r < D; r++) x ^= pkt(seed, r * L + c, w);
    return x;
  endfunction

  function automatic logic [7:0] rpar(logic [7:0] seed, int r, int w);
    logic [7:0] x = '0;
    for (int c = 0; c < L; c++) x ^= pkt(seed, r * L + c, w);
    return x;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic wr_media(int s, int w, logic [7:0] d);
    media_we = 1'b1; media_slot = 4'(s); media_word = 2'(w); media_data = d;
    @(negedge clk);
    media_we = 1'b0;
  endtask

  task automatic wr_par(bit row, int i, int w, logic [7:0] d);
    par_we = 1'b1; par_row = row; par_idx = 2'(i); par_word = 2'(w); par_data = d;
    @(negedge clk);
    par_we = 1'b0;
  endtask

  // R2: parity written first and in reverse index order, media last and reversed.
  task automatic load(logic [7:0] seed, logic [15:0] loss, logic [3:0] cm, logic [3:0] rm);
    for (int i = D - 1; i >= 0; i--)
      if (rm[i]) for (int w = 0; w < WORDS; w++) wr_par(1'b1, i, w, rpar(seed, i, w));
    for (int i = L - 1; i >= 0; i--)
      if (cm[i]) for (int w = 0; w < WORDS; w++) wr_par(1'b0, i, w, cpar(seed, i, w));
    for (int s = SLOTS - 1; s >= 0; s--)
      if (!loss[s]) for (int w = 0; w < WORDS; w++) wr_media(s, w, pkt(seed, s, w));
  endtask

  task automatic run(logic [7:0] seed, bit stray, output logic [15:0] recm, output int un);
    int wexp;
    bit got;
    recm = '0; un = -1; nrec = 0; wexp = 0; got = 0;
    @(negedge clk); close = 1'b1;
    @(negedge clk); close = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (stray && cyc == 0) begin  // R7 writes while busy
        media_we = 1'b1; media_slot = 4'd5; media_word = 2'd3; media_data = 8'hA5;
        par_we = 1'b1; par_row = 1'b0; par_idx = 2'd1; par_word = 2'd0; par_data = 8'h5A;
      end
      if (stray && cyc == 1) begin
        media_we = 1'b0; par_we = 1'b0;
      end
      if (out_valid) begin
        if (out_first) begin
          recm[out_slot] = 1'b1;
          if (nrec < SLOTS) rec_seq[nrec] = int'(out_slot);
          nrec++;
          wexp = 0;
        end
        check(int'(out_word) == wexp, "R4 word order", int'(out_word), wexp);
        check(out_data == pkt(seed, int'(out_slot), int'(out_word)), "R1 rebuilt word",
              int'(out_data), int'(pkt(seed, int'(out_slot), int'(out_word))));
        wexp++;
      end
      if (done) begin
        un = int'(unrec_cnt);
        got = 1;
        break;
      end
      @(negedge clk);
    end
    check(got, "R5 done pulse", int'(got), 1);
    @(negedge clk);
    check(!done, "R5 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [15:0] recm;
    int un;
    rst_n = 1'b0; media_we = 1'b0; par_we = 1'b0; par_row = 1'b0; close = 1'b0;
    media_slot = '0; media_word = '0; media_data = '0;
    par_idx = '0; par_word = '0; par_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check(!busy, "R9 busy", int'(busy), 0);
    check(!out_valid, "R9 out_valid", int'(out_valid), 0);
    check(!done, "R9 done", int'(done), 0);
    check(unrec_cnt == 5'd16, "R9 unrec_cnt", int'(unrec_cnt), 16);

    // Vector table; each run after the first also relies on R8 clearing.
    for (int v = 0; v < 10; v++) begin
      load(VECS[v].seed, VECS[v].loss, VECS[v].cm, VECS[v].rm);
      run(VECS[v].seed, 1'b0, recm, un);
      check(recm == VECS[v].exp_rec, "R1 R2 R6 recovered set", int'(recm), int'(VECS[v].exp_rec));
      check(un == int'(VECS[v].exp_un), "R5 unrecovered count", un, int'(VECS[v].exp_un));
      if (v == 4) begin  // R3 column sweep, then row, then column
        check(nrec == 3, "R3 packet count", nrec, 3);
        check(rec_seq[0] == 1, "R3 first slot", rec_seq[0], 1);
        check(rec_seq[1] == 0, "R3 second slot", rec_seq[1], 0);
        check(rec_seq[2] == 4, "R3 third slot", rec_seq[2], 4);
      end
    end

    // R7: stray media and parity writes during recovery change nothing
    load(8'd11, 16'h01E0, 4'hF, 4'h0);
    run(8'd11, 1'b1, recm, un);
    check(recm == 16'h01E0, "R7 recovered set", int'(recm), 16'h01E0);
    check(un == 0, "R7 unrecovered count", un, 0);

    // R8: words 0..2 without the last word leave the slot missing
    load(8'd12, 16'h0008, 4'hF, 4'h0);
    for (int w = 0; w < WORDS - 1; w++) wr_media(3, w, 8'hEE);
    run(8'd12, 1'b0, recm, un);
    check(recm == 16'h0008, "R8 partial packet recovered", int'(recm), 16'h0008);
    check(un == 0, "R8 unrecovered count", un, 0);

    // R8: matrix is empty after done
    check(unrec_cnt == 5'd16, "R8 cleared after done", int'(unrec_cnt), 16);

    report();
    $finish;
  end
endmodule